// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This unit sits between a 32-bit integer datapath and a word-wide data memory port. It turns a byte address, an access size and a store operand into a word address, per-lane write enables and lane-replicated write data. On the return path it picks the addressed byte or halfword out of the word the memory delivers and widens it to 32 bits, with sign or zero fill as the request asks. The effective address arrives already computed; the memory itself lies outside the block.

Lane numbering is big-endian: the byte at word offset 0 is the most significant byte of the memory word, so offset 0 lives in bits 31:24 and offset 3 in bits 7:0. Accesses must be naturally aligned. A request that breaks alignment raises a flag in the same cycle, writes no byte and produces no load result.

The memory read has a fixed latency of one cycle: the data word on `mem_rdata_i` in the cycle after an accepted load is the one for that load, and the unit keeps the size, offset and fill kind of the load in registers until then.

Top module: `belsu_lane_unit`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` with bits 1:0 forced to 0, in the same cycle, whether or not a request is valid.
- R2: A valid byte store (size code 0) drives exactly one enable: byte offset k sets `mem_be_o[3-k]`, where `mem_be_o[i]` covers `mem_wdata_o[8i+7:8i]`; `mem_wdata_o` holds `req_wdata_i[7:0]` in all four lanes.
- R3: A valid aligned halfword store (size code 1) sets `mem_be_o` to 4'b1100 for offset 0 and 4'b0011 for offset 2; `mem_wdata_o` holds `req_wdata_i[15:0]` in both halves.
- R4: A valid aligned word store (size code 2) sets `mem_be_o` to 4'b1111 and passes `req_wdata_i` unchanged.
- R5: `misalign_o` is 1 in the same cycle as a valid request that is a halfword with address bit 0 set, a word with address bits 1:0 not both 0, or uses the reserved size code 3; otherwise it is 0, and always 0 while `req_valid_i` is 0.
- R6: A misaligned request drives `mem_be_o` to 0 and `mem_re_o` to 0, and gives no `ld_valid_o` in the following cycle.
- R7: A valid aligned load (`req_write_i` = 0) drives `mem_be_o` to 0 and `mem_re_o` to 1; `ld_valid_o` is 1 in exactly the next cycle, and `ld_data_o` is then derived from `mem_rdata_i` of that cycle.
- R8: For a byte load at offset k the result is `mem_rdata_i[31-8k:24-8k]`, sign-extended when `req_unsigned_i` was 0 and zero-extended when it was 1.
- R9: For a halfword load, offset 0 selects `mem_rdata_i[31:16]` and offset 2 selects `mem_rdata_i[15:0]`, sign- or zero-extended as for R8.
- R10: A word load returns `mem_rdata_i` unchanged, whatever `req_unsigned_i` was.
- R11: While `rst_ni` is 0, `ld_valid_o` is 0, including a load result that was pending when reset arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned_i | input | 1 | Load fill: 1 zero, 0 sign |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store operand, right-justified |
| mem_addr_o | output | 32 | Word address to memory |
| mem_re_o | output | 1 | Read strobe to memory |
| mem_be_o | output | 4 | Write enable per byte lane |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word, one cycle after `mem_re_o` |
| misalign_o | output | 1 | Alignment violation of the current request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
Stores are tried at every offset and size with an operand whose bytes all differ, so a swapped or mirrored lane shows in both the enables and the data. Loads read a word holding bytes with the top bit set and clear (0x80, 0x7F, 0xFE, 0x01) at different offsets, which separates sign from zero fill and big-endian from little-endian selection. Misaligned halfword and word addresses and the reserved size code show that a bad request writes nothing and yields no load result, and back-to-back loads with differing read words show that each result is paired with the right return cycle.

// File: rtl/belsu_pkg.sv
package belsu_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/belsu_align_chk.sv
module belsu_align_chk
  import belsu_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o
);

  always_comb begin
    unique case (size_i)
      ACC_BYTE: misalign_o = 1'b0;
      ACC_HALF: misalign_o = off_i[0];
      ACC_WORD: misalign_o = |off_i;
      default:  misalign_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/belsu_store_lane.sv
module belsu_store_lane
  import belsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              wr_en_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);

  // Offset k addresses the lane k places below the top of the word.
  for (genvar k = 0; k < LANES; k++) begin : g_hit
    localparam int PHYS = LANES - 1 - k;
    logic hit;
    always_comb begin
      unique case (size_i)
        ACC_BYTE: hit = (off_i == OFF_W'(k));
        ACC_HALF: hit = (off_i[OFF_W-1:1] == (OFF_W-1)'(k / 2));
        ACC_WORD: hit = 1'b1;
        default:  hit = 1'b0;
      endcase
      be_o[PHYS] = wr_en_i & hit;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_data
    always_comb begin
      unique case (size_i)
        ACC_BYTE: wdata_o[8*i +: 8] = wdata_i[7:0];
        ACC_HALF: wdata_o[8*i +: 8] = wdata_i[8*(i % 2) +: 8];
        default:  wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
      endcase
    end
  end

endmodule

// File: rtl/belsu_load_extract.sv
module belsu_load_extract
  import belsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              zero_fill_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] aligned;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic              fill_b;
  logic              fill_h;

  // Shifting up by the offset brings the addressed item to the top.
  always_comb begin
    aligned = rdata_i << {off_i, 3'b000};
    sel_b   = aligned[DATA_W-1 -: 8];
    sel_h   = aligned[DATA_W-1 -: 16];
    fill_b  = ~zero_fill_i & sel_b[7];
    fill_h  = ~zero_fill_i & sel_h[15];
    unique case (size_i)
      ACC_BYTE: data_o = {{(DATA_W-8){fill_b}}, sel_b};
      ACC_HALF: data_o = {{(DATA_W-16){fill_h}}, sel_h};
      default:  data_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/belsu_lane_unit.sv
module belsu_lane_unit
  import belsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misalign_o,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);

  acc_size_e        req_size;
  logic [OFF_W-1:0] req_off;
  logic             bad_align;
  logic             wr_en;

  // Load context held across the one-cycle memory latency.
  logic             pend_d,  pend_q;
  acc_size_e        size_d,  size_q;
  logic [OFF_W-1:0] off_d,   off_q;
  logic             zero_d,  zero_q;
  logic             ctx_en;

  assign req_size   = acc_size_e'(req_size_i);
  assign req_off    = req_addr_i[OFF_W-1:0];
  assign mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  belsu_align_chk #(.OFF_W(OFF_W)) u_align (
    .size_i     (req_size),
    .off_i      (req_off),
    .misalign_o (bad_align)
  );

  assign misalign_o = req_valid_i & bad_align;
  assign wr_en      = req_valid_i & req_write_i & ~bad_align;
  assign mem_re_o   = req_valid_i & ~req_write_i & ~bad_align;

  belsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .wr_en_i (wr_en),
    .size_i  (req_size),
    .off_i   (req_off),
    .wdata_i (req_wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  always_comb begin
    pend_d = mem_re_o;
    ctx_en = mem_re_o;
    size_d = req_size;
    off_d  = req_off;
    zero_d = req_unsigned_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= ACC_BYTE;
      off_q  <= '0;
      zero_q <= 1'b0;
    end else if (ctx_en) begin
      size_q <= size_d;
      off_q  <= off_d;
      zero_q <= zero_d;
    end
  end

  assign ld_valid_o = pend_q;

  belsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .rdata_i     (mem_rdata_i),
    .size_i      (size_q),
    .off_i       (off_q),
    .zero_fill_i (zero_q),
    .data_o      (ld_data_o)
  );

  // Store lane enables
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size == ACC_BYTE) |-> ($countones(mem_be_o) == 1)); // R2
  AST_HALF_TWO_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size == ACC_HALF && !misalign_o) |-> ($countones(mem_be_o) == 2)); // R3
  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_size == ACC_WORD && !misalign_o) |-> (&mem_be_o)); // R4

  // Misaligned requests have no side effect
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0 && !mem_re_o)); // R6
  AST_MISALIGN_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !ld_valid_o); // R6

  // Load timing
  AST_LOAD_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |-> (mem_be_o == '0)); // R7
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ld_valid_o); // R7
  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(mem_re_o)); // R7

  // Fill of narrow loads
  AST_BYTE_SIGN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && size_q == ACC_BYTE && !zero_q) |-> (ld_data_o[DATA_W-1:8] == {(DATA_W-8){ld_data_o[7]}})); // R8
  AST_HALF_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && size_q == ACC_HALF && zero_q) |-> (ld_data_o[DATA_W-1:16] == '0)); // R9

endmodule

// File: tb/belsu_lane_unit_tb.sv
module belsu_lane_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_size;
  logic        req_unsigned;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] mem_addr;
  logic        mem_re;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state: the load expected to complete this cycle.
  logic       pend_v   = 1'b0;
  logic       pend_bad = 1'b0;
  int         pend_sz  = 0;
  int         pend_off = 0;
  logic       pend_u   = 1'b0;

  belsu_lane_unit dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_write_i    (req_write),
    .req_size_i     (req_size),
    .req_unsigned_i (req_unsigned),
    .req_addr_i     (req_addr),
    .req_wdata_i    (req_wdata),
    .mem_addr_o     (mem_addr),
    .mem_re_o       (mem_re),
    .mem_be_o       (mem_be),
    .mem_wdata_o    (mem_wdata),
    .mem_rdata_i    (mem_rdata),
    .misalign_o     (misalign),
    .ld_valid_o     (ld_valid),
    .ld_data_o      (ld_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic m_bad(int sz, logic [31:0] a);
    case (sz)
      0:       return 1'b0;
      1:       return a[0];
      2:       return a[1:0] != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] m_be(int sz, int off);
    case (sz)
      0:       return 4'b1000 >> off;
      1:       return (off == 0) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] m_wdata(int sz, logic [31:0] w);
    case (sz)
      0:       return {4{w[7:0]}};
      1:       return {2{w[15:0]}};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] m_load(int sz, int off, logic u, logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    case (off)
      0:       b = r[31:24];
      1:       b = r[23:16];
      2:       b = r[15:8];
      default: b = r[7:0];
    endcase
    h = (off == 0) ? r[31:16] : r[15:0];
    case (sz)
      0:       return u ? {24'h0, b} : {{24{b[7]}}, b};
      1:       return u ? {16'h0, h} : {{16{h[15]}}, h};
      default: return r;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; rd is the memory word answering last cycle's load.
  task automatic step(logic v, logic w, int sz, logic u, logic [31:0] a,
                      logic [31:0] wd, logic [31:0] rd);
    logic bad;
    string tg;
    @(negedge clk);
    req_valid    = v;
    req_write    = w;
    req_size     = 2'(sz);
    req_unsigned = u;
    req_addr     = a;
    req_wdata    = wd;
    mem_rdata    = rd;
    #1;
    bad = v & m_bad(sz, a);
    chk("R1 addr", mem_addr, {a[31:2], 2'b00});
    chk("R5 misalign", 32'(misalign), 32'(bad));
    if (bad) tg = "R6";
    else if (!v || !w) tg = "R7";
    else if (sz == 0) tg = "R2";
    else if (sz == 1) tg = "R3";
    else tg = "R4";
    chk({tg, " be"}, 32'(mem_be), (v && w && !bad) ? 32'(m_be(sz, a[1:0])) : 32'h0);
    chk({tg, " re"}, 32'(mem_re), 32'(v && !w && !bad));
    if (v && w && !bad) chk({tg, " wdata"}, mem_wdata, m_wdata(sz, wd));
    chk(pend_bad ? "R6 ld_valid" : "R7 ld_valid", 32'(ld_valid), 32'(pend_v));
    if (pend_v) begin
      if (pend_sz == 0) tg = "R8";
      else if (pend_sz == 1) tg = "R9";
      else tg = "R10";
      chk({tg, " ld_data"}, ld_data, m_load(pend_sz, pend_off, pend_u, rd));
    end
    pend_v   = v && !w && !bad;
    pend_bad = bad;
    pend_sz  = sz;
    pend_off = int'(a[1:0]);
    pend_u   = u;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [31:0] WD  = 32'h1234_56A5;
  localparam logic [31:0] RDA = 32'h807F_FE01;
  localparam logic [31:0] RDB = 32'h7F80_01FE;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_unsigned = 1'b0; req_addr = 32'h0; req_wdata = 32'h0; mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset ld_valid", 32'(ld_valid), 32'h0);
    chk("R11 reset be", 32'(mem_be), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Idle cycle: no misalign flag, address still forwarded (R1, R5)
    step(0, 0, 3, 0, 32'h0000_1003, WD, 32'h0);
    // Byte stores at every offset (R2)
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 32'h0000_2000 + 32'(k), WD, 32'h0);
    // Halfword and word stores (R3, R4)
    step(1, 1, 1, 0, 32'h0000_2000, WD, 32'h0);
    step(1, 1, 1, 0, 32'h0000_2002, WD, 32'h0);
    step(1, 1, 2, 0, 32'h0000_2004, WD, 32'h0);
    // Misaligned stores and reserved size (R5, R6)
    step(1, 1, 1, 0, 32'h0000_2001, WD, 32'h0);
    step(1, 1, 1, 0, 32'h0000_2003, WD, 32'h0);
    step(1, 1, 2, 0, 32'h0000_2002, WD, 32'h0);
    step(1, 1, 3, 0, 32'h0000_2000, WD, 32'h0);
    // Byte loads, signed and unsigned, back to back (R7, R8)
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++)
        step(1, 0, 0, logic'(u), 32'h0000_3000 + 32'(k), 32'h0, ((k + u) % 2 == 0) ? RDB : RDA);
    // Halfword loads (R9)
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k += 2)
        step(1, 0, 1, logic'(u), 32'h0000_3000 + 32'(k), 32'h0, (k == 0) ? RDB : RDA);
    // Word loads, fill request ignored (R10)
    step(1, 0, 2, 0, 32'h0000_3008, 32'h0, RDA);
    step(1, 0, 2, 1, 32'h0000_300C, 32'h0, RDA);
    // Misaligned loads give no result (R6)
    step(1, 0, 2, 0, 32'h0000_3001, 32'h0, RDB);
    step(1, 0, 1, 1, 32'h0000_3003, 32'h0, RDA);
    step(0, 0, 0, 0, 32'h0, 32'h0, RDB);
    // Pending load cleared by reset (R11)
    step(1, 0, 0, 0, 32'h0000_3000, 32'h0, RDA);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 pending cleared", 32'(ld_valid), 32'h0);
    pend_v = 1'b0;
    pend_bad = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 32'h0, 32'h0, RDB);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule